// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between the ready tracking of an out-of-order core and its execution units. Each operation class has its own small ready queue, which it keeps sorted by sequence number. On every clock the selector walks the classes in order of the age of their head instruction, oldest head first. It grants up to `ISSUE_W` instructions. A class whose units are all taken is passed over, and the walk moves on to younger classes. A class head that a squash has killed is dropped during the walk and does not use up an issue slot.

Upstream presents at most one newly ready instruction per cycle, tagged with its class, sequence number, thread and a memory flag. A squash request kills every queued entry of one thread that is younger than a given sequence number. Each grant carries tag, sequence number, class and thread. A non-memory grant releases its entry in the same slot. A memory grant does not: its entry is released later, when the completion input for that tag arrives.

Top module: `oldest_issue_sel`

## Requirements
- R1: After reset no grant, busy flag, full flag or memory release is asserted, and every class queue is empty.
- R2: Within one cycle, grants fill slot 0 upward with strictly increasing sequence numbers. At each step the walk takes the smallest head sequence number among the classes that are neither empty nor skipped.
- R3: A class issues its entries in ascending sequence order whatever their arrival order. A newly ready entry older than the current head of its class is issued first.
- R4: No more than `ISSUE_W` grants are made per cycle. Ready entries beyond that wait for later cycles.
- R5: Class c is granted at most `fuFree[c]` (2 bits per class) entries per cycle. When its head is reached with no unit left, the class is skipped for the rest of that cycle, `fuBusyHit[c]` is raised in the grant cycle, and the walk continues with younger classes.
- R6: `sqValid` marks every queued entry (including one inserted on the same edge) whose thread equals `sqThread` and whose sequence number is greater than `sqSeq`. Such an entry is never granted. Entries of other threads, and older entries, are unaffected.
- R7: A killed entry met at a class head is removed without taking an issue slot. Each cycle's walk has `ISSUE_W + CLS_N + SQ_POPS` steps, and any removals beyond that budget are left for the next cycle.
- R8: `relValid[i]` equals a valid grant in slot i whose memory flag (`grantMem`) is 0. One cycle after `memDoneValid`, `memRelValid` pulses with `memRelTag` equal to the completed tag.
- R9: An entry presented on `inValid` at a clock edge can be granted at the earliest on the following edge. Grants, busy flags and full flags are registered, using the queue contents before that edge and `fuFree` sampled at that edge.
- R10: `classFull[c]` is 1 exactly when class c holds `Q_DEPTH` entries. Upstream must not insert into a class that would overflow after this cycle's pops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | New ready instruction present |
| inClass | input | CLS_W | Operation class of the new instruction |
| inSeq | input | SEQ_W | Sequence number of the new instruction |
| inTag | input | TAG_W | Tag of the new instruction |
| inThread | input | THR_W | Thread of the new instruction |
| inMem | input | 1 | New instruction is a memory access |
| sqValid | input | 1 | Squash request |
| sqThread | input | THR_W | Thread being squashed |
| sqSeq | input | SEQ_W | Entries younger than this are killed |
| fuFree | input | CLS_N x FUC_W | Free unit count per class this cycle |
| memDoneValid | input | 1 | A memory instruction completed |
| memDoneTag | input | TAG_W | Tag of the completed memory instruction |
| grantValid | output | ISSUE_W | Issue slot valid |
| grantSeq | output | ISSUE_W x SEQ_W | Sequence number per slot |
| grantTag | output | ISSUE_W x TAG_W | Tag per slot |
| grantClass | output | ISSUE_W x CLS_W | Class per slot |
| grantThread | output | ISSUE_W x THR_W | Thread per slot |
| grantMem | output | ISSUE_W | Memory flag per slot |
| relValid | output | ISSUE_W | Entry released at issue, per slot |
| fuBusyHit | output | CLS_N | Class skipped for lack of a unit |
| classFull | output | CLS_N | Class queue full |
| memRelValid | output | 1 | Memory entry released |
| memRelTag | output | TAG_W | Tag of released memory entry |

## Verification
The hardest situation to reach from the ports is a single walk that mixes killed heads, a class skipped for lack of units and real grants. Only in that mix do the two separate counts, walk steps and issue slots, both matter. The stimulus holds `fuFree` at zero so that several classes fill up without issuing. It kills a run of one class's heads with a squash on the same edge as a fresh insertion, and then opens the units in one cycle. A behavioural model with plain arrays predicts every output on every clock, so a wrong ordering, a miscounted slot or a leaked killed entry shows up in the cycle it happens.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;
  parameter int CLS_N   = 4;
  parameter int Q_DEPTH = 4;
  parameter int SEQ_W   = 16;
  parameter int TAG_W   = 6;
  parameter int THR_W   = 1;
  parameter int FUC_W   = 2;
  parameter int CLS_W   = $clog2(CLS_N);
  parameter int CNT_W   = $clog2(Q_DEPTH + 1);

  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic [TAG_W-1:0] tag;
    logic [THR_W-1:0] thr;
    logic             isMem;
    logic             killed;
  } qEntry_t;

  // control -> datapath: how many entries leave each class head this cycle
  typedef struct packed {
    logic [CLS_N-1:0][CNT_W-1:0] popCnt;
  } selStrobe_t;
endpackage

// File: rtl/issue_sel_queues.sv
module issue_sel_queues
  import issue_sel_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  selStrobe_t                        strb,
  input  logic                              inValid,
  input  logic [CLS_W-1:0]                  inClass,
  input  qEntry_t                           inEnt,
  input  logic                              sqValid,
  input  logic [THR_W-1:0]                  sqThread,
  input  logic [SEQ_W-1:0]                  sqSeq,
  output qEntry_t [CLS_N-1:0][Q_DEPTH-1:0]  ent,
  output logic [CLS_N-1:0][CNT_W-1:0]       cnt
);
  qEntry_t [CLS_N-1:0][Q_DEPTH-1:0] nextEnt;
  logic [CLS_N-1:0][CNT_W-1:0]      nextCnt;

  for (genvar c = 0; c < CLS_N; c++) begin : g_cls
    qEntry_t [Q_DEPTH-1:0] shifted;
    qEntry_t [Q_DEPTH-1:0] merged;
    logic [CNT_W-1:0]      shCnt;
    logic [CNT_W-1:0]      mCnt;

    always_comb begin
      int pos;
      int pop;
      pop   = int'(strb.popCnt[c]);
      shCnt = cnt[c] - strb.popCnt[c];
      // drop the entries the walk consumed from the head
      for (int i = 0; i < Q_DEPTH; i++) begin
        if (i + pop < Q_DEPTH) shifted[i] = ent[c][i + pop];
        else                   shifted[i] = '0;
      end
      // sorted insertion position: number of older entries
      pos = 0;
      for (int i = 0; i < Q_DEPTH; i++)
        if (i < int'(shCnt) && shifted[i].seq < inEnt.seq) pos++;
      merged = shifted;
      mCnt   = shCnt;
      if (inValid && int'(inClass) == c) begin
        mCnt = shCnt + 1'b1;
        for (int i = 0; i < Q_DEPTH; i++) begin
          if (i == pos)     merged[i] = inEnt;
          else if (i > pos) merged[i] = shifted[(i > 0) ? i - 1 : 0];
        end
      end
      // squash marks younger entries of one thread, new arrival included
      for (int i = 0; i < Q_DEPTH; i++)
        if (sqValid && i < int'(mCnt) && merged[i].thr == sqThread &&
            merged[i].seq > sqSeq)
          merged[i].killed = 1'b1;
    end

    assign nextEnt[c] = merged;
    assign nextCnt[c] = mCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ent <= '0;
      cnt <= '0;
    end else begin
      ent <= nextEnt;
      cnt <= nextCnt;
    end
  end

  // ---- checks ----
  logic pastRun;
  always_ff @(posedge clk) pastRun <= rstN;

  always_ff @(posedge clk) begin
    if (rstN) begin
      for (int c = 0; c < CLS_N; c++)
        for (int i = 0; i + 1 < Q_DEPTH; i++)
          if (i + 1 < int'(cnt[c]))
            a_r3_class_sorted: assert (ent[c][i].seq < ent[c][i+1].seq)
              else $error("class %0d not sorted at %0d", c, i);
    end
  end

  for (genvar c = 0; c < CLS_N; c++) begin : g_chk
    a_r10_count_track: assert property (@(posedge clk) disable iff (!rstN || !pastRun)
      int'(cnt[c]) == int'($past(cnt[c])) - int'($past(strb.popCnt[c]))
                      + int'($past(inValid && int'(inClass) == c)));
  end

  a_r10_no_overfill: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (int'(cnt[inClass]) - int'(strb.popCnt[inClass]) < Q_DEPTH));
endmodule

// File: rtl/issue_sel_ctrl.sv
module issue_sel_ctrl
  import issue_sel_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int SQ_POPS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  qEntry_t [CLS_N-1:0][Q_DEPTH-1:0]  qEnt,
  input  logic [CLS_N-1:0][CNT_W-1:0]       qCnt,
  input  logic [CLS_N-1:0][FUC_W-1:0]       fuFree,
  output selStrobe_t                        strb,
  output logic [ISSUE_W-1:0]                grantValid,
  output qEntry_t [ISSUE_W-1:0]             grantEnt,
  output logic [ISSUE_W-1:0][CLS_W-1:0]     grantClass,
  output logic [CLS_N-1:0]                  busyHit
);
  localparam int STEPS = ISSUE_W + CLS_N + SQ_POPS;

  logic [ISSUE_W-1:0]            nValid;
  qEntry_t [ISSUE_W-1:0]         nEnt;
  logic [ISSUE_W-1:0][CLS_W-1:0] nClass;
  logic [CLS_N-1:0]              nSkip;

  always_comb begin
    int hd [CLS_N];
    int avail [CLS_N];
    int issued;
    int best;
    logic found;
    qEntry_t cand;
    nValid = '0;
    nEnt   = '0;
    nClass = '0;
    nSkip  = '0;
    issued = 0;
    best   = 0;
    found  = 1'b0;
    cand   = '0;
    for (int c = 0; c < CLS_N; c++) begin
      hd[c]    = 0;
      avail[c] = int'(fuFree[c]);
    end
    for (int s = 0; s < STEPS; s++) begin
      found = 1'b0;
      best  = 0;
      // oldest head among classes still in the walk
      for (int c = 0; c < CLS_N; c++)
        if (!nSkip[c] && hd[c] < int'(qCnt[c]))
          if (!found || qEnt[c][hd[c]].seq < qEnt[best][hd[best]].seq) begin
            found = 1'b1;
            best  = c;
          end
      if (found && issued < ISSUE_W) begin
        cand = qEnt[best][hd[best]];
        if (cand.killed) begin
          hd[best]++;
        end else if (avail[best] > 0) begin
          nValid[issued] = 1'b1;
          nEnt[issued]   = cand;
          nClass[issued] = CLS_W'(best);
          avail[best]--;
          hd[best]++;
          issued++;
        end else begin
          nSkip[best] = 1'b1;
        end
      end
    end
    for (int c = 0; c < CLS_N; c++) strb.popCnt[c] = CNT_W'(hd[c]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValid <= '0;
      grantEnt   <= '0;
      grantClass <= '0;
      busyHit    <= '0;
    end else begin
      grantValid <= nValid;
      grantEnt   <= nEnt;
      grantClass <= nClass;
      busyHit    <= nSkip;
    end
  end

  // ---- checks ----
  function automatic int grantsOf(input logic [ISSUE_W-1:0] v,
                                  input logic [ISSUE_W-1:0][CLS_W-1:0] k,
                                  input int c);
    int n;
    n = 0;
    for (int i = 0; i < ISSUE_W; i++) if (v[i] && int'(k[i]) == c) n++;
    return n;
  endfunction

  for (genvar i = 1; i < ISSUE_W; i++) begin : g_ord
    a_r2_slot_age_order: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> (grantValid[i-1] && grantEnt[i-1].seq < grantEnt[i].seq));
  end

  for (genvar c = 0; c < CLS_N; c++) begin : g_fu
    a_r5_units_respected: assert property (@(posedge clk) disable iff (!rstN)
      grantsOf(grantValid, grantClass, c) <= int'($past(fuFree[c])));
  end
endmodule

// File: rtl/oldest_issue_sel.sv
module oldest_issue_sel
  import issue_sel_pkg::*;
#(
  parameter int ISSUE_W = 2,
  parameter int SQ_POPS = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              inValid,
  input  logic [CLS_W-1:0]                  inClass,
  input  logic [SEQ_W-1:0]                  inSeq,
  input  logic [TAG_W-1:0]                  inTag,
  input  logic [THR_W-1:0]                  inThread,
  input  logic                              inMem,
  input  logic                              sqValid,
  input  logic [THR_W-1:0]                  sqThread,
  input  logic [SEQ_W-1:0]                  sqSeq,
  input  logic [CLS_N-1:0][FUC_W-1:0]       fuFree,
  input  logic                              memDoneValid,
  input  logic [TAG_W-1:0]                  memDoneTag,
  output logic [ISSUE_W-1:0]                grantValid,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]     grantSeq,
  output logic [ISSUE_W-1:0][TAG_W-1:0]     grantTag,
  output logic [ISSUE_W-1:0][CLS_W-1:0]     grantClass,
  output logic [ISSUE_W-1:0][THR_W-1:0]     grantThread,
  output logic [ISSUE_W-1:0]                grantMem,
  output logic [ISSUE_W-1:0]                relValid,
  output logic [CLS_N-1:0]                  fuBusyHit,
  output logic [CLS_N-1:0]                  classFull,
  output logic                              memRelValid,
  output logic [TAG_W-1:0]                  memRelTag
);
  selStrobe_t                       strb;
  qEntry_t [CLS_N-1:0][Q_DEPTH-1:0] qEnt;
  logic [CLS_N-1:0][CNT_W-1:0]      qCnt;
  qEntry_t [ISSUE_W-1:0]            grantEnt;
  qEntry_t                          inEnt;

  assign inEnt = '{seq: inSeq, tag: inTag, thr: inThread, isMem: inMem, killed: 1'b0};

  issue_sel_queues u_queues (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inValid(inValid), .inClass(inClass), .inEnt(inEnt),
    .sqValid(sqValid), .sqThread(sqThread), .sqSeq(sqSeq),
    .ent(qEnt), .cnt(qCnt)
  );

  issue_sel_ctrl #(.ISSUE_W(ISSUE_W), .SQ_POPS(SQ_POPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .qEnt(qEnt), .qCnt(qCnt), .fuFree(fuFree),
    .strb(strb), .grantValid(grantValid), .grantEnt(grantEnt),
    .grantClass(grantClass), .busyHit(fuBusyHit)
  );

  for (genvar i = 0; i < ISSUE_W; i++) begin : g_slot
    assign grantSeq[i]    = grantEnt[i].seq;
    assign grantTag[i]    = grantEnt[i].tag;
    assign grantThread[i] = grantEnt[i].thr;
    assign grantMem[i]    = grantEnt[i].isMem;
    assign relValid[i]    = grantValid[i] && !grantEnt[i].isMem;

    a_r6_no_killed_grant: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[i] |-> !grantEnt[i].killed);
  end

  for (genvar c = 0; c < CLS_N; c++) begin : g_full
    assign classFull[c] = (int'(qCnt[c]) == Q_DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRelValid <= 1'b0;
      memRelTag   <= '0;
    end else begin
      memRelValid <= memDoneValid;
      memRelTag   <= memDoneTag;
    end
  end

  a_r8_mem_release: assert property (@(posedge clk) disable iff (!rstN)
    memDoneValid |=> (memRelValid && memRelTag == $past(memDoneTag)));
endmodule

// File: tb/oldest_issue_sel_tb.sv
module oldest_issue_sel_tb;
  import issue_sel_pkg::*;
  localparam int ISSUE_W = 2;
  localparam int SQ_POPS = 2;
  localparam int STEPS   = ISSUE_W + CLS_N + SQ_POPS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [CLS_W-1:0] inClass = '0;
  logic [SEQ_W-1:0] inSeq = '0;
  logic [TAG_W-1:0] inTag = '0;
  logic [THR_W-1:0] inThread = '0;
  logic inMem = 1'b0;
  logic sqValid = 1'b0;
  logic [THR_W-1:0] sqThread = '0;
  logic [SEQ_W-1:0] sqSeq = '0;
  logic [CLS_N-1:0][FUC_W-1:0] fu = '0;
  logic memDoneValid = 1'b0;
  logic [TAG_W-1:0] memDoneTag = '0;

  logic [ISSUE_W-1:0] grantValid, grantMem, relValid;
  logic [ISSUE_W-1:0][SEQ_W-1:0] grantSeq;
  logic [ISSUE_W-1:0][TAG_W-1:0] grantTag;
  logic [ISSUE_W-1:0][CLS_W-1:0] grantClass;
  logic [ISSUE_W-1:0][THR_W-1:0] grantThread;
  logic [CLS_N-1:0] fuBusyHit, classFull;
  logic memRelValid;
  logic [TAG_W-1:0] memRelTag;

  oldest_issue_sel #(.ISSUE_W(ISSUE_W), .SQ_POPS(SQ_POPS)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .inSeq(inSeq),
    .inTag(inTag), .inThread(inThread), .inMem(inMem), .sqValid(sqValid),
    .sqThread(sqThread), .sqSeq(sqSeq), .fuFree(fu), .memDoneValid(memDoneValid),
    .memDoneTag(memDoneTag), .grantValid(grantValid), .grantSeq(grantSeq),
    .grantTag(grantTag), .grantClass(grantClass), .grantThread(grantThread),
    .grantMem(grantMem), .relValid(relValid), .fuBusyHit(fuBusyHit),
    .classFull(classFull), .memRelValid(memRelValid), .memRelTag(memRelTag)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  string curReq = "R1";

  // behavioural reference state
  int mSeq [CLS_N][Q_DEPTH];
  int mTag [CLS_N][Q_DEPTH];
  int mThr [CLS_N][Q_DEPTH];
  bit mMem [CLS_N][Q_DEPTH];
  bit mKill[CLS_N][Q_DEPTH];
  int mCnt [CLS_N];
  bit eV[ISSUE_W]; int eSeq[ISSUE_W]; int eTag[ISSUE_W]; int eCls[ISSUE_W];
  int eThr[ISSUE_W]; bit eMem[ISSUE_W];
  bit eBusy[CLS_N];
  bit eMemRV; int eMemRT;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d", req, curReq, what, act, exp);
    end
  endtask

  task automatic modelStep();
    int taken[CLS_N]; int units[CLS_N]; bit out[CLS_N]; int n; int b;
    n = 0;
    for (int i = 0; i < ISSUE_W; i++) begin
      eV[i] = 0; eSeq[i] = 0; eTag[i] = 0; eCls[i] = 0; eThr[i] = 0; eMem[i] = 0;
    end
    for (int c = 0; c < CLS_N; c++) begin
      taken[c] = 0; units[c] = int'(fu[c]); out[c] = 0; eBusy[c] = 0;
    end
    for (int s = 0; s < STEPS; s++) begin
      b = -1;
      for (int c = 0; c < CLS_N; c++)
        if (!out[c] && taken[c] < mCnt[c])
          if (b < 0 || mSeq[c][taken[c]] < mSeq[b][taken[b]]) b = c;
      if (b >= 0 && n < ISSUE_W) begin
        if (mKill[b][taken[b]]) taken[b]++;
        else if (units[b] > 0) begin
          eV[n] = 1; eSeq[n] = mSeq[b][taken[b]]; eTag[n] = mTag[b][taken[b]];
          eCls[n] = b; eThr[n] = mThr[b][taken[b]]; eMem[n] = mMem[b][taken[b]];
          units[b]--; taken[b]++; n++;
        end else begin
          out[b] = 1; eBusy[b] = 1;
        end
      end
    end
    for (int c = 0; c < CLS_N; c++) begin
      for (int k = 0; k < taken[c]; k++) begin
        for (int i = 0; i + 1 < Q_DEPTH; i++) begin
          mSeq[c][i] = mSeq[c][i+1]; mTag[c][i] = mTag[c][i+1]; mThr[c][i] = mThr[c][i+1];
          mMem[c][i] = mMem[c][i+1]; mKill[c][i] = mKill[c][i+1];
        end
      end
      mCnt[c] -= taken[c];
    end
    if (inValid) begin
      int c; int j;
      c = int'(inClass); j = mCnt[c];
      mSeq[c][j] = int'(inSeq); mTag[c][j] = int'(inTag); mThr[c][j] = int'(inThread);
      mMem[c][j] = inMem; mKill[c][j] = 0;
      while (j > 0 && mSeq[c][j-1] > mSeq[c][j]) begin
        int ts; int tt; int th; bit tm;
        ts = mSeq[c][j]; tt = mTag[c][j]; th = mThr[c][j]; tm = mMem[c][j];
        mSeq[c][j] = mSeq[c][j-1]; mTag[c][j] = mTag[c][j-1]; mThr[c][j] = mThr[c][j-1];
        mMem[c][j] = mMem[c][j-1]; mKill[c][j] = mKill[c][j-1];
        mSeq[c][j-1] = ts; mTag[c][j-1] = tt; mThr[c][j-1] = th; mMem[c][j-1] = tm;
        mKill[c][j-1] = 0;
        j--;
      end
      mCnt[c]++;
    end
    if (sqValid)
      for (int c = 0; c < CLS_N; c++)
        for (int i = 0; i < mCnt[c]; i++)
          if (mThr[c][i] == int'(sqThread) && mSeq[c][i] > int'(sqSeq)) mKill[c][i] = 1;
    eMemRV = memDoneValid; eMemRT = int'(memDoneTag);
  endtask

  task automatic compareAll();
    for (int i = 0; i < ISSUE_W; i++) begin
      chk(grantValid[i] == eV[i], "R2", $sformatf("slot%0d valid", i), int'(grantValid[i]), int'(eV[i]));
      if (eV[i] && grantValid[i]) begin
        chk(int'(grantTag[i]) == eTag[i], "R2", $sformatf("slot%0d tag", i), int'(grantTag[i]), eTag[i]);
        chk(int'(grantSeq[i]) == eSeq[i], "R2", $sformatf("slot%0d seq", i), int'(grantSeq[i]), eSeq[i]);
        chk(int'(grantClass[i]) == eCls[i], "R2", $sformatf("slot%0d class", i), int'(grantClass[i]), eCls[i]);
        chk(int'(grantThread[i]) == eThr[i], "R6", $sformatf("slot%0d thread", i), int'(grantThread[i]), eThr[i]);
        chk(grantMem[i] == eMem[i], "R8", $sformatf("slot%0d mem", i), int'(grantMem[i]), int'(eMem[i]));
      end
      chk(relValid[i] == (eV[i] && !eMem[i]), "R8", $sformatf("slot%0d release", i),
          int'(relValid[i]), int'(eV[i] && !eMem[i]));
    end
    for (int c = 0; c < CLS_N; c++) begin
      chk(fuBusyHit[c] == eBusy[c], "R5", $sformatf("busy class%0d", c), int'(fuBusyHit[c]), int'(eBusy[c]));
      chk(classFull[c] == (mCnt[c] == Q_DEPTH), "R10", $sformatf("full class%0d", c),
          int'(classFull[c]), int'(mCnt[c] == Q_DEPTH));
    end
    chk(memRelValid == eMemRV, "R8", "mem release valid", int'(memRelValid), int'(eMemRV));
    if (eMemRV) chk(int'(memRelTag) == eMemRT, "R8", "mem release tag", int'(memRelTag), eMemRT);
  endtask

  task automatic cycle();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    inValid = 0; sqValid = 0; memDoneValid = 0;
    compareAll();
  endtask

  task automatic put(input int c, input int s, input int t, input int th, input bit m);
    inValid = 1; inClass = CLS_W'(c); inSeq = SEQ_W'(s); inTag = TAG_W'(t);
    inThread = THR_W'(th); inMem = m;
    cycle();
  endtask

  task automatic allFree();
    for (int c = 0; c < CLS_N; c++) fu[c] = FUC_W'(1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nErr++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CLS_N; c++) mCnt[c] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk(grantValid == '0, "R1", "grants after reset", int'(grantValid), 0);
    chk(classFull == '0 && fuBusyHit == '0, "R1", "flags after reset",
        int'(classFull) + int'(fuBusyHit), 0);
    chk(memRelValid == 1'b0, "R1", "mem release after reset", int'(memRelValid), 0);
    cycle();

    // R2: oldest head across classes goes first
    curReq = "R2"; fu = '0;
    put(0, 30, 1, 0, 0); put(1, 10, 2, 0, 0); put(2, 20, 3, 0, 0);
    allFree(); cycle();
    chk(grantValid[0] && grantTag[0] == 2 && grantTag[1] == 3, "R2", "first pair tags",
        int'(grantTag[0]), 2);
    cycle();
    chk(grantValid[0] && grantTag[0] == 1, "R2", "third grant", int'(grantTag[0]), 1);

    // R3: in-class order and an older late arrival
    curReq = "R3"; fu = '0;
    put(3, 50, 4, 0, 0); put(3, 40, 5, 0, 0); put(3, 45, 6, 0, 0);
    fu[3] = 2'd3; cycle();
    chk(grantTag[0] == 5 && grantTag[1] == 6, "R3", "sorted within class", int'(grantTag[0]), 5);
    fu = '0; put(3, 35, 7, 0, 0);
    fu[3] = 2'd1; cycle();
    chk(grantValid[0] && grantTag[0] == 7, "R3", "older arrival first", int'(grantTag[0]), 7);
    cycle();
    chk(grantValid[0] && grantTag[0] == 4, "R3", "remaining head", int'(grantTag[0]), 4);

    // R4: width limit
    curReq = "R4"; fu = '0;
    put(0, 60, 8, 0, 0); put(1, 61, 9, 0, 0); put(2, 62, 10, 0, 0); put(3, 63, 11, 0, 0);
    allFree(); cycle();
    chk($countones(grantValid) == ISSUE_W, "R4", "grants capped", $countones(grantValid), ISSUE_W);
    cycle();
    chk(grantTag[0] == 10 && grantTag[1] == 11, "R4", "leftovers next cycle", int'(grantTag[0]), 10);

    // R5: busy classes skipped, walk continues
    curReq = "R5"; fu = '0;
    put(0, 70, 12, 0, 0); put(0, 71, 13, 0, 0); put(1, 72, 14, 0, 0); put(2, 73, 15, 0, 0);
    fu[0] = 2'd1; fu[1] = 2'd0; fu[2] = 2'd1; fu[3] = 2'd0; cycle();
    chk(grantTag[0] == 12 && grantTag[1] == 15, "R5", "younger class after skip", int'(grantTag[1]), 15);
    chk(fuBusyHit == 4'b0011, "R5", "busy flags", int'(fuBusyHit), 3);
    allFree(); cycle();
    chk(grantTag[0] == 13 && grantTag[1] == 14, "R5", "skipped ones later", int'(grantTag[0]), 13);

    // R6 / R7 / R10: squash, free removal of killed heads, full flag
    curReq = "R6"; fu = '0;
    put(0, 90, 21, 1, 0);
    put(2, 101, 16, 1, 0); put(2, 102, 17, 1, 0); put(2, 103, 18, 1, 0); put(2, 110, 19, 0, 0);
    chk(classFull[2] == 1'b1, "R10", "class 2 full", int'(classFull[2]), 1);
    sqValid = 1; sqThread = 1'b1; sqSeq = 16'd100;
    put(1, 120, 20, 0, 0);
    curReq = "R7"; allFree(); cycle();
    chk(grantTag[0] == 21 && grantTag[1] == 19, "R7", "killed heads free", int'(grantTag[1]), 19);
    cycle();
    chk(grantValid[0] && grantTag[0] == 20, "R6", "other thread kept", int'(grantTag[0]), 20);
    chk(grantValid[1] == 1'b0, "R6", "nothing killed leaks", int'(grantValid[1]), 0);

    // R8: release rules
    curReq = "R8"; fu = '0;
    put(0, 130, 22, 0, 1); put(1, 131, 23, 0, 0);
    allFree(); cycle();
    chk(relValid == 2'b10, "R8", "mem keeps entry", int'(relValid), 2);
    memDoneValid = 1; memDoneTag = 6'd22; cycle();
    chk(memRelValid && memRelTag == 22, "R8", "mem completion release", int'(memRelTag), 22);

    // R9: one-edge latency from insert to grant
    curReq = "R9"; allFree();
    put(0, 140, 24, 0, 0);
    chk(grantValid == '0, "R9", "no grant on insert edge", int'(grantValid), 0);
    cycle();
    chk(grantValid[0] && grantTag[0] == 24, "R9", "grant next edge", int'(grantTag[0]), 24);

    curReq = "idle";
    repeat (3) cycle();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule